// File: doc/BRIEF.md
# Event Time Stamp Capture Unit

This block freezes a copy of the running calendar (a time field and a date field) when a qualified event occurs. There are two event sources. The first is an external pin, which is brought into the clock domain by a two-flop synchronizer and then edge-detected with a selectable polarity. The second is a one-cycle tamper-event pulse from a neighbouring tamper detector. The pin path is used only when stamping is enabled, and the tamper path only when its own enable is set. Both sources merge into one event strobe, so a pin edge and a tamper pulse that land on the same edge yield one capture.

A capture sets a captured flag, and an interrupt request follows it when the interrupt enable is set. If an event arrives while a capture is still unacknowledged, the stored stamp is kept and an overflow flag is raised instead. This includes the cycle in which the flag is still on its way to becoming visible. Software acknowledges each flag with its own clear strobe. A set condition in the same cycle as a clear wins.

Top module: `evstamp_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stamp outputs, `flag_o`, `ovf_o` and `irq_o` all become 0.
- R2: With `stamp_en_i`=1, a pin edge of the selected polarity captures the calendar. `pol_fall_i`=0 selects a rising edge and `pol_fall_i`=1 selects a falling edge. For a pin change set up before clock edge k, `{stamp_date_o, stamp_time_o}` takes `{cal_date_i, cal_time_i}` as sampled at edge k+2.
- R3: With `stamp_en_i`=0, pin edges of either polarity change neither the stamp nor any flag.
- R4: A pin edge of the polarity not selected changes neither the stamp nor any flag.
- R5: A tamper pulse on `tamp_evt_i` sampled at edge E captures the calendar at E when `tamp_stamp_en_i`=1, whatever `stamp_en_i` is. When `tamp_stamp_en_i`=0 the pulse has no effect.
- R6: `flag_o` stays 0 after the edge that loads the stamp and reads 1 after the following edge, which is two edges after the event was first presented.
- R7: An event sampled while `flag_o` is 1, or while a capture from the previous edge is pending, sets `ovf_o` at that edge and leaves the stamp unchanged.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R9: `clr_flag_i` and `clr_ovf_i` clear their flag at the edge they are sampled. If the same flag has a set condition at that edge, the flag ends up 1.
- R10: A pin edge and a tamper pulse that qualify at the same edge produce one capture, and `ovf_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Calendar-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_time_i | input | TIME_W | Present time field of the calendar |
| cal_date_i | input | DATE_W | Present date field of the calendar |
| pin_i | input | 1 | Asynchronous stamp pin |
| tamp_evt_i | input | 1 | One-cycle tamper-event pulse |
| pol_fall_i | input | 1 | 0: rising pin edge, 1: falling pin edge |
| stamp_en_i | input | 1 | Enables capture from the pin |
| tamp_stamp_en_i | input | 1 | Enables capture from tamper events |
| irq_en_i | input | 1 | Interrupt enable |
| clr_flag_i | input | 1 | Clear strobe for the captured flag |
| clr_ovf_i | input | 1 | Clear strobe for the overflow flag |
| stamp_time_o | output | TIME_W | Stored time field |
| stamp_date_o | output | DATE_W | Stored date field |
| flag_o | output | 1 | Captured flag |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle here. A synchronized pin edge can meet a tamper pulse, and a flag's set condition can meet its clear strobe. The bench lines up the first pair by raising the pin two edges ahead of the tamper pulse, so both qualify at the same edge. It then judges that the stamp carries that edge's calendar value, that the flag is set and that the overflow flag stays clear. For the second pair, it drives a clear strobe into the edge where a pending capture, or an overflowing event, sets the flag. It then expects the flag to read 1, and expects the strobe alone on the next edge to clear it.

// File: rtl/evstamp_pkg.sv
// Shared definitions for the event time stamp capture unit.
package evstamp_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/evstamp_pinsync.sv
// Brings the asynchronous stamp pin into the clock domain and reports
// one-cycle edges of the selected polarity.
// Assumes: pin_i may change at any time; arm_i and pol_i are quasi-static.
module evstamp_pinsync
    import evstamp_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_i,
    input  edge_pol_e pol_i,
    input  logic      arm_i,
    output logic      edge_o
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
    logic [STAGES:0] chain;
    logic            lvl_now;
    logic            lvl_old;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            // Shift the pin level one flop further per clock
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= pin_i;
                else
                    chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign lvl_now = chain[STAGES-1];
    assign lvl_old = chain[STAGES];

    // Compare synchronized level with its history for the chosen edge
    always_comb begin
        if (pol_i == EDGE_FALL)
            edge_o = arm_i & ~lvl_now & lvl_old;
        else
            edge_o = arm_i & lvl_now & ~lvl_old;
    end

    AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(arm_i) && $stable(pol_i)) |=> !edge_o); // R2
endmodule

// File: rtl/evstamp_ctrl.sv
// Merges the event sources, decides capture versus overflow, and keeps
// the captured and overflow flags plus the interrupt request.
// Assumes: tamp_i is a single-cycle pulse; clear strobes are synchronous.
module evstamp_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_evt_i,
    input  logic tamp_i,
    input  logic tamp_ts_en_i,
    input  logic irq_en_i,
    input  logic clr_flag_i,
    input  logic clr_ovf_i,
    output logic load_o,
    output logic flag_o,
    output logic ovf_o,
    output logic irq_o
);
    logic evt;
    logic busy;
    logic pend_q;
    logic flag_q;
    logic ovf_q;

    // One strobe for either source, so coincident events capture once
    assign evt    = pin_evt_i | (tamp_i & tamp_ts_en_i);
    // A capture is outstanding from its load edge until software clears it
    assign busy   = pend_q | flag_q;
    assign load_o = evt & ~busy;

    // Delay stage that makes the flag appear one edge after the load
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= load_o;
    end

    // Captured flag: set from the delay stage, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (pend_q)     flag_q <= 1'b1;
        else if (clr_flag_i) flag_q <= 1'b0;
    end

    // Overflow flag: set by an event that finds a capture outstanding
    always_ff @(posedge clk) begin
        if (!rst_n)            ovf_q <= 1'b0;
        else if (evt && busy)  ovf_q <= 1'b1;
        else if (clr_ovf_i)    ovf_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign ovf_o  = ovf_q;
    assign irq_o  = flag_q & irq_en_i;

    AST_FLAG_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !flag_q); // R6
    AST_FLAG_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ##2 flag_q); // R6
    AST_OVF_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && busy) |=> ovf_q); // R7
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && clr_flag_i) |=> flag_q); // R9
    AST_CLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag_i && !pend_q) |=> !flag_q); // R9
endmodule

// File: rtl/evstamp_hold.sv
// Holding register for the captured calendar value.
// Assumes: load_i is asserted for at most one edge per capture.
module evstamp_hold #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Take the calendar on load, otherwise keep the stored stamp
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o)); // R7
    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(d_i))); // R2
endmodule

// File: rtl/evstamp_top.sv
// Event time stamp capture unit: pin synchronizer and edge detector,
// capture/overflow control and the stamp holding register.
// Assumes: calendar bus is synchronous to clk; tamper pulse is one cycle.
module evstamp_top
    import evstamp_pkg::*;
#(
    parameter int unsigned TIME_W = 24,
    parameter int unsigned DATE_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] cal_time_i,
    input  logic [DATE_W-1:0] cal_date_i,
    input  logic              pin_i,
    input  logic              tamp_evt_i,
    input  logic              pol_fall_i,
    input  logic              stamp_en_i,
    input  logic              tamp_stamp_en_i,
    input  logic              irq_en_i,
    input  logic              clr_flag_i,
    input  logic              clr_ovf_i,
    output logic [TIME_W-1:0] stamp_time_o,
    output logic [DATE_W-1:0] stamp_date_o,
    output logic              flag_o,
    output logic              ovf_o,
    output logic              irq_o
);
    localparam int unsigned CAL_W = TIME_W + DATE_W;

    logic             pin_edge;
    logic             load;
    logic [CAL_W-1:0] stamp_q;

    evstamp_pinsync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .pol_i  (edge_pol_e'(pol_fall_i)),
        .arm_i  (stamp_en_i),
        .edge_o (pin_edge)
    );

    evstamp_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pin_evt_i    (pin_edge),
        .tamp_i       (tamp_evt_i),
        .tamp_ts_en_i (tamp_stamp_en_i),
        .irq_en_i     (irq_en_i),
        .clr_flag_i   (clr_flag_i),
        .clr_ovf_i    (clr_ovf_i),
        .load_o       (load),
        .flag_o       (flag_o),
        .ovf_o        (ovf_o),
        .irq_o        (irq_o)
    );

    evstamp_hold #(.W(CAL_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .d_i    ({cal_date_i, cal_time_i}),
        .q_o    (stamp_q)
    );

    assign stamp_time_o = stamp_q[TIME_W-1:0];
    assign stamp_date_o = stamp_q[CAL_W-1:TIME_W];

    AST_NO_PIN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!stamp_en_i && !(tamp_evt_i && tamp_stamp_en_i) && !flag_o)
            |=> $stable(stamp_q)); // R3
endmodule

// File: tb/sim_evstamp_top.sv
`timescale 1ns/1ps
module sim_evstamp_top;
    localparam int unsigned TW = 24;
    localparam int unsigned DW = 24;
    localparam int unsigned NV = 8;

    typedef struct packed {
        logic        is_pin;
        logic        fall;
        logic        en;
        logic        ten;
        logic        pfrom;
        logic        pto;
        logic [23:0] cal;
        logic        cap;
    } vec_t;

    // is_pin fall en ten pfrom pto cal cap
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 24'h102030, 1'b1}, // R2 rise
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 24'h405060, 1'b1}, // R2 fall
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 24'h0A0B0C, 1'b0}, // R3
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 24'h111111, 1'b0}, // R4
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 24'h222222, 1'b0}, // R4
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'h334455, 1'b1}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h667788, 1'b0}, // R5
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h99AABB, 1'b1}  // R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] cal_time = '0;
    logic [DW-1:0] cal_date = '0;
    logic          pin = 1'b0, tamp = 1'b0, pol_fall = 1'b0;
    logic          stamp_en = 1'b0, tamp_en = 1'b0, irq_en = 1'b0;
    logic          clr_flag = 1'b0, clr_ovf = 1'b0;
    logic [TW-1:0] st_time;
    logic [DW-1:0] st_date;
    logic          flag, ovf, irq;

    int total = 0;
    int fails = 0;
    logic [47:0] exp_stamp = '0;

    always #2.5 clk = ~clk;

    evstamp_top #(.TIME_W(TW), .DATE_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_time_i(cal_time), .cal_date_i(cal_date),
        .pin_i(pin), .tamp_evt_i(tamp), .pol_fall_i(pol_fall),
        .stamp_en_i(stamp_en), .tamp_stamp_en_i(tamp_en), .irq_en_i(irq_en),
        .clr_flag_i(clr_flag), .clr_ovf_i(clr_ovf),
        .stamp_time_o(st_time), .stamp_date_o(st_date),
        .flag_o(flag), .ovf_o(ovf), .irq_o(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cal(input logic [23:0] v);
        cal_time = v;
        cal_date = v ^ 24'h5A5A5A;
    endtask

    function automatic logic [47:0] cal_of(input logic [23:0] v);
        return {v ^ 24'h5A5A5A, v};
    endfunction

    task automatic clear_all();
        clr_flag = 1'b1; clr_ovf = 1'b1;
        @(negedge clk);
        clr_flag = 1'b0; clr_ovf = 1'b0;
    endtask

    task automatic pulse_tamper();
        tamp = 1'b1;
        @(negedge clk);
        tamp = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        stamp_en = 1'b0; tamp_en = 1'b0;
        pin = v.pfrom;
        repeat (4) @(negedge clk);
        clear_all();
        set_cal(v.cal);
        pol_fall = v.fall; stamp_en = v.en; tamp_en = v.ten;
        @(negedge clk);
        if (v.is_pin) begin
            pin = v.pto;
            repeat (5) @(negedge clk);
        end else begin
            pulse_tamper();
            repeat (4) @(negedge clk);
        end
        if (v.cap) exp_stamp = cal_of(v.cal);
        check("R2/R3/R4/R5 stamp", {st_date, st_time}, exp_stamp);
        check("R2/R3/R4/R5 flag", flag, v.cap);
        check("R7 no overflow", ovf, 1'b0);
    endtask

    // Watchdog: an expired run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 stamp", {st_date, st_time}, 48'h0);
        check("R1 flag", flag, 1'b0);
        check("R1 ovf", ovf, 1'b0);
        check("R1 irq", irq, 1'b0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R6 flag timing, R5 load edge, R8 interrupt gating
        stamp_en = 1'b0; tamp_en = 1'b1; irq_en = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
        clear_all();
        set_cal(24'hABCDEF);
        pulse_tamper();
        check("R5 stamp at first edge", {st_date, st_time}, cal_of(24'hABCDEF));
        check("R6 flag not yet", flag, 1'b0);
        @(negedge clk);
        check("R6 flag after second edge", flag, 1'b1);
        check("R8 irq masked", irq, 1'b0);
        irq_en = 1'b1; #1;
        check("R8 irq enabled", irq, 1'b1);

        // R7 event while flag set
        set_cal(24'h123456);
        @(negedge clk);
        pulse_tamper();
        check("R7 stamp kept", {st_date, st_time}, cal_of(24'hABCDEF));
        check("R7 overflow set", ovf, 1'b1);

        // R7 event while capture pending
        clear_all(); irq_en = 1'b0;
        @(negedge clk);
        set_cal(24'h0C0C0C);
        tamp = 1'b1;
        @(negedge clk);
        set_cal(24'h0D0D0D);
        @(negedge clk);
        tamp = 1'b0;
        check("R7 pending stamp kept", {st_date, st_time}, cal_of(24'h0C0C0C));
        check("R7 pending overflow", ovf, 1'b1);

        // R9 set beats clear on the flag
        clear_all();
        @(negedge clk);
        set_cal(24'h777777);
        pulse_tamper();
        clr_flag = 1'b1;
        @(negedge clk);
        check("R9 flag set wins", flag, 1'b1);
        @(negedge clk);
        clr_flag = 1'b0;
        check("R9 flag cleared", flag, 1'b0);

        // R9 set beats clear on overflow
        pulse_tamper();
        repeat (2) @(negedge clk);
        clr_ovf = 1'b1;
        pulse_tamper();
        check("R9 ovf set wins", ovf, 1'b1);
        @(negedge clk);
        clr_ovf = 1'b0;
        check("R9 ovf cleared", ovf, 1'b0);

        // R10 coincident pin edge and tamper pulse
        clear_all();
        stamp_en = 1'b1; pol_fall = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
        set_cal(24'h5E5E5E);
        pin = 1'b1;
        repeat (2) @(negedge clk);
        pulse_tamper();
        check("R10 single capture stamp", {st_date, st_time}, cal_of(24'h5E5E5E));
        repeat (3) @(negedge clk);
        check("R10 flag", flag, 1'b1);
        check("R10 no overflow", ovf, 1'b0);

        // R1 reset while flags are set
        irq_en = 1'b1;
        pulse_tamper();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 stamp after reset", {st_date, st_time}, 48'h0);
        check("R1 flags after reset", {flag, ovf, irq}, 3'b000);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule